// File: doc/BRIEF.md
# Dual-Channel I/Q Capture Recorder

The recorder takes baseband samples from two receive channels and stores them in an on-chip sample memory. Each channel delivers a signed 12-bit in-phase value and a signed 12-bit quadrature value with its own valid strobe. When both strobes are high in the same cycle, the block widens the four values to 16-bit two's-complement words and writes them as one 8-byte group. The groups go to consecutive addresses in a byte-addressed image.

Software first arms the block and programs a capture length in bytes. Recording then begins on one of two events. The first is a start pulse from software. The second is a rising edge on an external trigger pin, which lets several units begin acquisition together. Recording ends once the programmed number of bytes has been stored.

A host then reads the image back in fixed bursts of `BURST_BYTES`. Each burst is streamed one 16-bit word per cycle from a byte offset that the host supplies. Any word that lies past the recorded length reads as zero.

Top module: `iq_capture_rec`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `rd_err` are all low.
- R2: The block leaves idle only on `cfg_arm`. A start or trigger event has no effect unless the block is armed. Arming clears `done` and latches the length. `cfg_arm` is ignored while recording.
- R3: With `cfg_ext_sel` = 0, a `cfg_start` pulse while armed raises `busy` on the next clock edge, and `ext_trig` is ignored.
- R4: With `cfg_ext_sel` = 1, `ext_trig` passes through a two-flop synchronizer and only its rising edge starts recording. Let e0 be the first clock edge that samples `ext_trig` high. `busy` is then seen after the third edge counted from e0, and not before it. In this mode `cfg_start` is ignored.
- R5: Each cycle in which `busy` is high and both `ch0_valid` and `ch1_valid` are high stores one group at byte address 8·g, where g counts groups from 0 for the current recording. The group holds channel-0 I at +0, channel-0 Q at +2, channel-1 I at +4 and channel-1 Q at +6. Each value is sign-extended from bit 11 into a 16-bit word.
- R6: A sample cycle in which only one channel strobe is high is discarded. A sample cycle that arrives while not recording is also discarded.
- R7: The latched length is rounded down to a multiple of 8 and capped at the memory size in bytes. On the clock edge that stores the last group, `busy` falls and `done` rises. A length below 8 sets `done` one edge after the start event and stores nothing. `busy` and `done` are never high together.
- R8: `done` stays high until the next `cfg_arm`. Samples arriving after the length is reached are discarded, and the write address never wraps.
- R9: When no burst is active, `rd_req` starts a burst from byte offset `rd_offset` rounded down to a multiple of 8. One edge after acceptance, `rd_valid` is high for `BURST_BYTES`/2 consecutive cycles, and `rd_data` gives the words in ascending byte order. A `rd_req` during an active burst is ignored.
- R10: Words whose group lies at or past the recorded group count read as zero. `rd_err` is updated on the accepting edge and holds until the next accepted request. It is high when the burst extends past the recorded length or when `rd_offset` is not a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arm | input | 1 | Arm pulse; latches `cfg_len_bytes` |
| cfg_start | input | 1 | Software start pulse |
| cfg_ext_sel | input | 1 | 1 selects the external trigger as start source |
| cfg_len_bytes | input | AW+4 | Capture length in bytes |
| ext_trig | input | 1 | Asynchronous external trigger |
| ch0_valid | input | 1 | Channel 0 sample strobe |
| ch0_i | input | 12 | Channel 0 in-phase, signed |
| ch0_q | input | 12 | Channel 0 quadrature, signed |
| ch1_valid | input | 1 | Channel 1 sample strobe |
| ch1_i | input | 12 | Channel 1 in-phase, signed |
| ch1_q | input | 12 | Channel 1 quadrature, signed |
| busy | output | 1 | Recording in progress |
| done | output | 1 | Programmed length reached |
| rd_req | input | 1 | Burst read request |
| rd_offset | input | AW+4 | Burst start byte offset |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| rd_err | output | 1 | Last accepted burst overran the record or was unaligned |

## Verification
Three situations are hard to reach from the ports. The first is a `cfg_arm` that lands in the middle of a recording. The second is a cycle where only one channel strobes. The third is a read burst that straddles the recorded end from an unaligned offset.

The bench interleaves strobes from a single channel every third cycle and pulses arm partway through longer captures. It then sweeps every burst position across a small memory, including one past the end. The bench also holds the trigger source it did not select active before the real start, so a start that leaks through would be caught.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_REC   = 2'd2
    } cap_state_e;

    localparam int SMP_W  = 12;
    localparam int WORD_W = 16;
    localparam int LANES  = 4;

    function automatic logic [WORD_W-1:0] widen12(input logic [SMP_W-1:0] v);
        return {{(WORD_W - SMP_W){v[SMP_W-1]}}, v};
    endfunction

endpackage

// File: rtl/iqcap_trig_sync.sv
module iqcap_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] sh_d, sh_q;

    // two synchronizer stages plus one history stage for edge detection
    always_comb begin
        sh_d = {sh_q[1:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/iqcap_ram.sv
module iqcap_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/iqcap_reader.sv
module iqcap_reader #(
    parameter int AW          = 9,
    parameter int GW          = 10,
    parameter int OFF_W       = 13,
    parameter int BURST_BYTES = 1024,
    localparam int BURST_GROUPS = BURST_BYTES / 8,
    localparam int BURST_WORDS  = BURST_BYTES / 2,
    localparam int WIDX_W       = $clog2(BURST_WORDS),
    localparam int XW           = GW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [OFF_W-1:0] rd_offset,
    input  logic [GW-1:0]    rec_groups,
    output logic [AW-1:0]    ram_raddr,
    input  logic [63:0]      ram_rdata,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             rd_err,
    output logic             zero_o
);
    typedef struct packed {
        logic              active;
        logic [WIDX_W-1:0] widx;
        logic [XW-1:0]     base;
        logic              err;
        logic              valid;
        logic [1:0]        lane;
        logic              zero;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [XW-1:0] cur_grp;
    logic [XW-1:0] req_end;
    logic          misalign;

    assign cur_grp  = rd_q.base + XW'(rd_q.widx >> 2);
    assign req_end  = XW'(rd_offset >> 3) + XW'(BURST_GROUPS);
    assign misalign = |rd_offset[2:0];
    assign ram_raddr = cur_grp[AW-1:0];

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = 1'b0;
        if (!rd_q.active) begin
            if (rd_req) begin
                rd_d.active = 1'b1;
                rd_d.widx   = '0;
                rd_d.base   = XW'(rd_offset >> 3);
                rd_d.err    = misalign || (req_end > {1'b0, rec_groups});
            end
        end else begin
            rd_d.valid = 1'b1;
            rd_d.lane  = rd_q.widx[1:0];
            rd_d.zero  = (cur_grp >= {1'b0, rec_groups});
            rd_d.widx  = rd_q.widx + 1'b1;
            if (rd_q.widx == WIDX_W'(BURST_WORDS - 1)) rd_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_q.zero) begin
            unique case (rd_q.lane)
                2'd0: rd_data = ram_rdata[15:0];
                2'd1: rd_data = ram_rdata[31:16];
                2'd2: rd_data = ram_rdata[47:32];
                default: rd_data = ram_rdata[63:48];
            endcase
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_err   = rd_q.err;
    assign zero_o   = rd_q.zero;
endmodule

// File: rtl/iq_capture_rec.sv
module iq_capture_rec #(
    parameter int DEPTH_GROUPS = 512,
    parameter int BURST_BYTES  = 1024,
    localparam int AW    = $clog2(DEPTH_GROUPS),
    localparam int GW    = AW + 1,
    localparam int LEN_W = AW + 4,
    localparam int OFF_W = AW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_arm,
    input  logic             cfg_start,
    input  logic             cfg_ext_sel,
    input  logic [LEN_W-1:0] cfg_len_bytes,
    input  logic             ext_trig,
    input  logic             ch0_valid,
    input  logic [11:0]      ch0_i,
    input  logic [11:0]      ch0_q,
    input  logic             ch1_valid,
    input  logic [11:0]      ch1_i,
    input  logic [11:0]      ch1_q,
    output logic             busy,
    output logic             done,
    input  logic             rd_req,
    input  logic [OFF_W-1:0] rd_offset,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             rd_err
);
    import iqcap_pkg::*;

    typedef struct packed {
        cap_state_e    state;
        logic [GW-1:0] len_grp;
        logic [GW-1:0] wr_grp;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                trig_rise;
    logic                go;
    logic                wr_en;
    logic [LEN_W-1:0]    len_grp_full;
    logic [GW-1:0]       len_grp_cap;
    logic [SMP_W-1:0]    lane_raw [LANES];
    logic [LANES*WORD_W-1:0] grp_word;
    logic [AW-1:0]       ram_raddr;
    logic [63:0]         ram_rdata;
    logic                armed_w;
    logic [GW-1:0]       wr_groups_w;
    logic                rd_zero_w;

    iqcap_trig_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig),
        .rise_o  (trig_rise)
    );

    assign go           = cfg_ext_sel ? trig_rise : cfg_start;
    assign len_grp_full = cfg_len_bytes >> 3;
    assign len_grp_cap  = (len_grp_full > LEN_W'(DEPTH_GROUPS)) ? GW'(DEPTH_GROUPS)
                                                                : len_grp_full[GW-1:0];
    assign wr_en = (ctl_q.state == CAP_REC) && ch0_valid && ch1_valid;

    // lane order inside a group is fixed: ch0 I, ch0 Q, ch1 I, ch1 Q
    assign lane_raw[0] = ch0_i;
    assign lane_raw[1] = ch0_q;
    assign lane_raw[2] = ch1_i;
    assign lane_raw[3] = ch1_q;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_pack
        assign grp_word[ln*WORD_W +: WORD_W] = widen12(lane_raw[ln]);
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            CAP_IDLE: begin
                if (cfg_arm) begin
                    ctl_d.state   = CAP_ARMED;
                    ctl_d.done    = 1'b0;
                    ctl_d.len_grp = len_grp_cap;
                end
            end
            CAP_ARMED: begin
                if (cfg_arm) begin
                    ctl_d.len_grp = len_grp_cap;
                end else if (go) begin
                    ctl_d.wr_grp = '0;
                    if (ctl_q.len_grp == '0) begin
                        ctl_d.state = CAP_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = CAP_REC;
                    end
                end
            end
            CAP_REC: begin
                if (wr_en) begin
                    ctl_d.wr_grp = ctl_q.wr_grp + GW'(1);
                    if (ctl_q.wr_grp + GW'(1) == ctl_q.len_grp) begin
                        ctl_d.state = CAP_IDLE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            default: ctl_d.state = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state   <= CAP_IDLE;
            ctl_q.len_grp <= '0;
            ctl_q.wr_grp  <= '0;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.state == CAP_REC);
    assign done        = ctl_q.done;
    assign armed_w     = (ctl_q.state == CAP_ARMED);
    assign wr_groups_w = ctl_q.wr_grp;

    iqcap_ram #(
        .DEPTH (DEPTH_GROUPS),
        .WIDTH (LANES*WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (ctl_q.wr_grp[AW-1:0]),
        .wdata (grp_word),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    iqcap_reader #(
        .AW          (AW),
        .GW          (GW),
        .OFF_W       (OFF_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_offset  (rd_offset),
        .rec_groups (ctl_q.wr_grp),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_err     (rd_err),
        .zero_o     (rd_zero_w)
    );
endmodule

// File: rtl/iqcap_checker.sv
module iqcap_checker #(
    parameter int DEPTH_GROUPS = 512,
    parameter int GW           = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          cfg_arm,
    input logic          armed,
    input logic [GW-1:0] wr_groups,
    input logic          rd_valid,
    input logic          rd_zero,
    input logic [15:0]   rd_data
);
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                                   // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_arm) |=> done);                                       // R8

    AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));                                      // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_groups <= GW'(DEPTH_GROUPS));                                    // R8

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (wr_groups == $past(wr_groups)) || (wr_groups == $past(wr_groups) + GW'(1))); // R5

    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_zero) |-> (rd_data == 16'h0000));                   // R10
endmodule

bind iq_capture_rec iqcap_checker #(
    .DEPTH_GROUPS (DEPTH_GROUPS),
    .GW           (GW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cfg_arm   (cfg_arm),
    .armed     (armed_w),
    .wr_groups (wr_groups_w),
    .rd_valid  (rd_valid),
    .rd_zero   (rd_zero_w),
    .rd_data   (rd_data)
);

// File: tb/test_iq_capture_rec.sv
`timescale 1ns/1ps
module test_iq_capture_rec;
    localparam int DG    = 16;
    localparam int BB    = 32;
    localparam int BG    = BB / 8;
    localparam int BW    = BB / 2;
    localparam int LEN_W = $clog2(DG) + 4;
    localparam int OFF_W = $clog2(DG) + 4;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_arm, cfg_start, cfg_ext_sel, ext_trig;
    logic [LEN_W-1:0] cfg_len_bytes;
    logic ch0_valid, ch1_valid;
    logic [11:0] ch0_i, ch0_q, ch1_i, ch1_q;
    logic busy, done;
    logic rd_req;
    logic [OFF_W-1:0] rd_offset;
    logic rd_valid, rd_err;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_groups = 0;
    int cur_seed   = 0;

    always #2.5 clk = ~clk;

    iq_capture_rec #(.DEPTH_GROUPS(DG), .BURST_BYTES(BB)) i_iq_capture_rec (
        .clk(clk), .rst_n(rst_n),
        .cfg_arm(cfg_arm), .cfg_start(cfg_start), .cfg_ext_sel(cfg_ext_sel),
        .cfg_len_bytes(cfg_len_bytes), .ext_trig(ext_trig),
        .ch0_valid(ch0_valid), .ch0_i(ch0_i), .ch0_q(ch0_q),
        .ch1_valid(ch1_valid), .ch1_i(ch1_i), .ch1_q(ch1_q),
        .busy(busy), .done(done),
        .rd_req(rd_req), .rd_offset(rd_offset),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
    );

    function automatic logic [11:0] smp(int seed, int g, int l);
        int v;
        v = (seed * 97 + g * 131 + l * 1031 + 5) % 4096;
        if ((g + l) % 7 == 0) v = 2048;
        if ((g + l) % 7 == 3) v = 2047;
        return v[11:0];
    endfunction

    function automatic logic [15:0] sx(logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic junk(bit both);
        ch0_valid = 1'b1; ch1_valid = both;
        ch0_i = 12'h5A5; ch0_q = 12'hA5A; ch1_i = 12'h3C3; ch1_q = 12'hC3C;
    endtask

    task automatic idle_lanes();
        ch0_valid = 1'b0; ch1_valid = 1'b0;
    endtask

    task automatic read_burst(int off);
        int base;
        bit exp_err;
        base    = off / 8;
        exp_err = (off % 8 != 0) || (base + BG > exp_groups);
        rd_offset = OFF_W'(off);
        rd_req    = 1'b1;
        tick();
        rd_req = 1'b0;
        chk(rd_err == exp_err, "R10 err flag", rd_err, exp_err);
        chk(!rd_valid, "R9 no data on accept edge", rd_valid, 0);
        for (int k = 0; k < BW; k++) begin
            int grp;
            logic [15:0] ev;
            tick();
            grp = base + k / 4;
            ev  = (grp < exp_groups) ? sx(smp(cur_seed, grp, k % 4)) : 16'h0000;
            chk(rd_valid, "R9 burst valid", rd_valid, 1);
            chk(rd_data == ev, (grp < exp_groups) ? "R5 R9 word" : "R10 zero fill",
                rd_data, ev);
            rd_req    = (k == 2);
            rd_offset = (k == 2) ? OFF_W'(8) : OFF_W'(off);
        end
        rd_req = 1'b0;
        tick();
        chk(!rd_valid, "R9 burst length", rd_valid, 0);
        chk(rd_err == exp_err, "R10 err held", rd_err, exp_err);
    endtask

    task automatic capture(int seed, int len, bit ext);
        int g;
        int c;
        exp_groups = (len / 8 > DG) ? DG : len / 8;
        // samples before arming are discarded
        junk(1'b1);
        tick();
        idle_lanes();
        cfg_ext_sel   = ext;
        cfg_len_bytes = LEN_W'(len);
        cfg_arm = 1'b1;
        tick();
        cfg_arm = 1'b0;
        chk(!done && !busy, "R2 arm clears done", done, 0);
        junk(1'b1);
        tick();
        idle_lanes();
        chk(!busy, "R6 armed samples ignored", busy, 0);
        if (ext) begin
            cfg_start = 1'b1;
            tick();
            cfg_start = 1'b0;
            tick();
            chk(!busy && !done, "R4 soft start ignored", busy, 0);
            ext_trig = 1'b1;
            tick();
            chk(!busy, "R4 no start after edge 1", busy, 0);
            tick();
            chk(!busy && !done, "R4 no start after edge 2", busy, 0);
            tick();
            if (exp_groups > 0) chk(busy, "R4 start after edge 3", busy, 1);
            else                chk(done && !busy, "R7 zero length done", done, 1);
            ext_trig = 1'b0;
        end else begin
            ext_trig = 1'b1;
            repeat (4) tick();
            chk(!busy && !done, "R3 ext trigger ignored", busy, 0);
            ext_trig = 1'b0;
            repeat (3) tick();
            cfg_start = 1'b1;
            tick();
            cfg_start = 1'b0;
            if (exp_groups > 0) chk(busy, "R3 soft start", busy, 1);
            else                chk(done && !busy, "R7 zero length done", done, 1);
        end
        cur_seed = seed;
        g = 0;
        c = 0;
        while (busy && c < 1000) begin
            if (c % 3 == 2) begin
                junk(1'b0);
            end else begin
                ch0_valid = 1'b1; ch1_valid = 1'b1;
                ch0_i = smp(seed, g, 0); ch0_q = smp(seed, g, 1);
                ch1_i = smp(seed, g, 2); ch1_q = smp(seed, g, 3);
                g++;
            end
            cfg_arm = (c == 4);
            tick();
            c++;
        end
        cfg_arm = 1'b0;
        idle_lanes();
        chk(g == exp_groups, "R7 group count", g, exp_groups);
        chk(done && !busy, "R7 done at length", done, 1);
        junk(1'b1);
        repeat (4) tick();
        idle_lanes();
        chk(done && !busy, "R8 done held, late samples ignored", done, 1);
        for (int b = 0; b <= DG / BG; b++) begin
            read_burst(b * BG * 8 + ((b == 1) ? 3 : 0));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_arm = 1'b0; cfg_start = 1'b0; cfg_ext_sel = 1'b0; ext_trig = 1'b0;
        cfg_len_bytes = '0;
        idle_lanes();
        ch0_i = '0; ch0_q = '0; ch1_i = '0; ch1_q = '0;
        rd_req = 1'b0; rd_offset = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(!busy && !done && !rd_valid && !rd_err, "R1 reset state",
            {busy, done, rd_valid, rd_err}, 0);
        cfg_start = 1'b1;
        tick();
        cfg_start = 1'b0;
        tick();
        chk(!busy && !done, "R2 start without arm ignored", busy, 0);
        read_burst(0);
        capture(1, 40, 1'b0);
        capture(2, 13, 1'b1);
        capture(3, 0, 1'b0);
        capture(4, 7, 1'b1);
        capture(5, 128, 1'b0);
        capture(6, 200, 1'b1);
        capture(7, 69, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule